// File: doc/BRIEF.md
# Eight-Bit Addressable Latch and Demultiplexer

The block holds eight single-bit values. One data line and a three-bit address choose which bit is written. Two active-low controls, a clear and an enable, select one of four modes. In latch mode, the addressed bit is transparent to the data line and every other bit keeps its value. In hold mode, nothing changes. In demultiplexer mode, the addressed output copies the data line, the other seven outputs are low and the stored bits are wiped. In clear mode, every output is low and the stored bits are wiped.

The storage is level-sensitive, one latch per bit, and no clock is used. A serial stream is turned into a parallel word by stepping the address while the enable is pulsed low once per bit. The enable should be held inactive while the address moves. Several instances can be combined by gating their enables from a higher-order address decode.

Top module: `addr_latch8`

## Requirements
- R1: With clear_n high and enable_n low, output q[addr] follows din while it is held, and keeps the last value of din after enable_n rises.
- R2: In latch mode, every output whose index differs from addr keeps its previous value.
- R3: With clear_n high and enable_n high, all outputs keep their values whatever din and addr do.
- R4: With clear_n low and enable_n low, q[addr] equals din and every other output is 0.
- R5: With clear_n low and enable_n high, all outputs are 0 whatever din and addr do.
- R6: Clear takes effect as soon as clear_n falls, with no clock and no enable edge involved.
- R7: addr is a plain binary index with addr[0] as the least significant bit: value k selects q[k].
- R8: While clear_n is low, in either clear or demultiplexer mode, every stored bit is reset to 0. A later return to hold mode therefore shows all zeros until new data is written.
- R9: Stepping addr from 0 to 7 with one enable_n low pulse per address, and with din set to bit k of a word at step k, leaves that word on q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clear_n | input | 1 | Active-low clear; selects clear or demultiplexer mode when low |
| enable_n | input | 1 | Active-low write/decode enable |
| addr | input | 3 | Binary bit index, addr[0] least significant |
| din | input | 1 | Data written to, or routed to, the addressed bit |
| q | output | 8 | Parallel outputs, q[k] for index k |

## Verification
Clear and a pending write can meet in the same instant. In that case clear_n falls while enable_n is still low with data on the addressed bit, so the block moves from latch mode straight into demultiplexer mode. The bench creates this case mid-cycle, away from any clock edge. It expects the addressed output to track din, the other outputs to drop at once and the store to read zero after a return to hold. The same case is repeated with enable_n high, which must blank all outputs without waiting for a clock.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

    localparam int DEF_ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_e;

    function automatic mode_e pick_mode(input logic clear_n, input logic enable_n);
        mode_e m;
        case ({clear_n, enable_n})
            2'b10:   m = MODE_LATCH;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
    import alatch_pkg::*;
(
    input  logic  clear_n,
    input  logic  enable_n,
    output mode_e mode
);
    always_comb mode = pick_mode(clear_n, enable_n);
endmodule

// File: rtl/alatch_addr_dec.sv
module alatch_addr_dec #(
    parameter  int ADDR_W = 3,
    localparam int N      = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      hit
);
    for (genvar k = 0; k < N; k++) begin : g_hit
        assign hit[k] = (addr == ADDR_W'(k));
    end
endmodule

// File: rtl/alatch_cell.sv
module alatch_cell (
    input  logic clear_n,
    input  logic wr,
    input  logic din,
    output logic state
);
    always_latch begin
        if (!clear_n)
            state <= 1'b0;
        else if (wr)
            state <= din;
    end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import alatch_pkg::*;
#(
    parameter  int ADDR_W = DEF_ADDR_W,
    localparam int N      = 1 << ADDR_W
) (
    input  logic              clear_n,
    input  logic              enable_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [N-1:0]      q
);
    mode_e          mode;
    logic [N-1:0]   hit;
    logic [N-1:0]   wr;
    logic [N-1:0]   stored;

    alatch_mode_dec u_mode (
        .clear_n  (clear_n),
        .enable_n (enable_n),
        .mode     (mode)
    );

    alatch_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign wr[i] = (mode == MODE_LATCH) && hit[i];

        alatch_cell u_cell (
            .clear_n (clear_n),
            .wr      (wr[i]),
            .din     (din),
            .state   (stored[i])
        );

        always_comb begin
            case (mode)
                MODE_LATCH, MODE_HOLD: q[i] = stored[i];
                MODE_DEMUX:            q[i] = hit[i] & din;
                default:               q[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        // R5
        clear_zero_chk: assert (mode != MODE_CLEAR || q == '0);
        // R4
        demux_single_chk: assert (mode != MODE_DEMUX || $countones(q) <= 1);
        // R1
        latch_follow_chk: assert (mode != MODE_LATCH || q[addr] == din);
        // R8
        cleared_store_chk: assert (clear_n || stored == '0);
    end

endmodule

// File: tb/test_addr_latch8.sv
module test_addr_latch8;

    logic       clk = 1'b0;
    logic       clear_n;
    logic       enable_n;
    logic [2:0] addr;
    logic       din;
    logic [7:0] q;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [7:0] mdl_mem  = '0;
    string      cur_req  = "R5";
    bit         live     = 1'b0;

    always #10 clk = ~clk;

    addr_latch8 i_addr_latch8 (
        .clear_n  (clear_n),
        .enable_n (enable_n),
        .addr     (addr),
        .din      (din),
        .q        (q)
    );

    function automatic logic [7:0] expect_q();
        logic [7:0] e;
        if (clear_n && !enable_n)      e = mdl_mem;
        else if (clear_n && enable_n)  e = mdl_mem;
        else if (!clear_n && !enable_n) begin
            e = '0;
            e[addr] = din;
        end else                        e = '0;
        return e;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_checks++;
        if (q !== exp) begin
            n_errors++;
            $display("FAIL %s: q=%b expected=%b (clr_n=%b en_n=%b addr=%0d din=%b)",
                     req, q, exp, clear_n, enable_n, addr, din);
        end
    endtask

    always @(posedge clk) if (live) check(cur_req, expect_q());

    task automatic apply(input logic c, input logic g, input logic [2:0] a,
                         input logic dv, input string req);
        @(negedge clk);
        clear_n = c; enable_n = g; addr = a; din = dv; cur_req = req;
        if (!c) mdl_mem = '0;
        else if (!g) mdl_mem[a] = dv;
    endtask

    task automatic write_bit(input logic [2:0] a, input logic dv, input string req);
        apply(1'b1, 1'b1, a, dv, "R3");
        apply(1'b1, 1'b0, a, dv, req);
        apply(1'b1, 1'b1, a, dv, "R3");
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] word;
        clear_n = 1'b0; enable_n = 1'b1; addr = '0; din = 1'b1;
        #3;
        check("R5 reset state", 8'h00);
        live = 1'b1;

        // R3 / R8: hold after clear shows zeros while din and addr wander
        for (int k = 0; k < 8; k++) apply(1'b1, 1'b1, 3'(k), k[0], "R3 R8");

        // R9 / R7 / R1: serial load
        word = 8'b1011_0010;
        for (int k = 0; k < 8; k++) write_bit(3'(k), word[k], "R1 R7 R9");
        @(negedge clk); #2;
        check("R9 serial word", word);

        // R2: overwrite one bit, others stay
        write_bit(3'd6, 1'b1, "R1 R2");
        @(negedge clk); #2;
        check("R2 single overwrite", word | 8'h40);

        // R1: transparency while held low
        apply(1'b1, 1'b0, 3'd0, 1'b1, "R1");
        apply(1'b1, 1'b0, 3'd0, 1'b0, "R1");
        apply(1'b1, 1'b0, 3'd0, 1'b1, "R1");
        apply(1'b1, 1'b1, 3'd0, 1'b1, "R1");

        // R3: hold with inputs toggling
        for (int k = 0; k < 8; k++) apply(1'b1, 1'b1, 3'(7 - k), ~k[0], "R3");
        @(negedge clk); #2;
        check("R3 hold kept", word | 8'h41);

        // R4 / R7: demultiplexer sweep
        for (int k = 0; k < 8; k++) begin
            apply(1'b0, 1'b0, 3'(k), 1'b1, "R4 R7");
            apply(1'b0, 1'b0, 3'(k), 1'b0, "R4");
        end

        // R8: store wiped by demux mode
        apply(1'b1, 1'b1, 3'd5, 1'b1, "R8");
        @(negedge clk); #2;
        check("R8 zero after demux", 8'h00);

        // reload, then async clear racing a pending write
        write_bit(3'd3, 1'b1, "R1");
        write_bit(3'd5, 1'b1, "R1");
        apply(1'b1, 1'b0, 3'd2, 1'b1, "R1");
        @(posedge clk); #3;
        clear_n = 1'b0;
        mdl_mem = '0;
        cur_req = "R6 R4";
        #1;
        check("R6 demux mid-cycle", 8'h04);
        enable_n = 1'b1;
        #1;
        check("R6 clear mid-cycle", 8'h00);
        cur_req = "R5 R6";

        // R5: clear with inputs toggling
        for (int k = 0; k < 8; k++) apply(1'b0, 1'b1, 3'(k), k[1], "R5");

        // R8: back to hold reads zero
        apply(1'b1, 1'b1, 3'd3, 1'b1, "R8");
        @(negedge clk); #2;
        check("R8 zero after clear", 8'h00);

        // R9 second pattern
        word = 8'b0110_1101;
        for (int k = 0; k < 8; k++) write_bit(3'(k), word[k], "R9");
        @(negedge clk); #2;
        check("R9 second word", word);

        live = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule